// File: doc/BRIEF.md
# SMBus Host-Notify Receiver with Address Snoop

This block listens passively on an SMBus segment through its SCL and SDA inputs. It has two jobs. The first is to act as the host's slave. When a master writes to a programmable host address, the block treats the transfer as a write word. It takes the byte in the command position as the notifying device's own address, then takes the following 16-bit word (low byte first). A command byte whose upper five bits are `11110` announces a 10-bit device address, and the byte that follows it is kept as the upper capture byte. The block acknowledges every byte it needs for this transfer by pulling SDA low during the ninth clock.

The second job is to watch a second programmable address, for reads and for writes alike, and keep the byte that follows the address. It never acknowledges these transfers. Nothing is committed until a STOP closes a transfer that carried enough bytes. The commit loads the capture registers and sets a sticky status flag, which software clears by writing 1.

Software reaches the block through a small register port with a combinational read. Select 0 is the host address and select 1 is the snoop address; both hold the address in bits 7:1 and read bit 0 as zero. Select 2 is the device-address capture, select 3 is the data word, and select 4 is status. In the status register, bit 0 is the host flag and bit 1 is the snoop flag.

Top module: `smbNotifySnoop`

## Requirements
- R1: After reset, selects 0 and 1 read 0x0010, selects 2, 3 and 4 read 0x0000, and `sdaPullLow` is 0.
- R2: A write to select 0 or 1 stores write-data bits 7:1 and bit 0 reads back as 0. Writes to selects 2 and 3 change nothing.
- R3: Consider a transfer whose address byte has bits 7:1 equal to the host address and bit 0 = 0 (write), followed by command, low and high bytes and then a STOP. It leaves select 2 = {8'h00, command[7:1], 1'b0}, select 3 = {high, low}, and status bit 0 set. The same address with bit 0 = 1 (read) is not a host match.
- R4: When the host command byte has bits 7:3 = 5'b11110, the byte right after it goes to select 2 bits 15:8, and the data word follows it, low byte first.
- R5: Status bits change only at the STOP that closes a transfer. After all bytes have been received and before the STOP, status still reads 0.
- R6: Consider a transfer whose address bits 7:1 equal the snoop address, with either R/W value, closed by a STOP after at least one further byte. It leaves select 2 = {8'h00, that byte} and sets status bit 1. Select 3 is left unchanged.
- R7: When the snoop and host addresses are equal, status bit 1 is never set, and a read to that address changes no register. A write to that address behaves as in R3.
- R8: `sdaPullLow` is asserted during the ninth clock only after the address, command, optional extension and two data bytes of a host match. Snooped transfers, unmatched addresses and surplus bytes are not acknowledged.
- R9: A STOP or repeated START that arrives before the required bytes leaves selects 2, 3 and 4 unchanged. After a repeated START, address reception begins again and a complete transfer is accepted.
- R10: Writing 1 to a status bit clears it, and writing 0 leaves it as it is. A commit and a clear of the same bit in the same clock leave the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | SMBus clock line as seen on the bus |
| sdaIn | input | 1 | SMBus data line as seen on the bus |
| sdaPullLow | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register select (0 host, 1 snoop, 2 capture, 3 data, 4 status) |
| regWrData | input | 8 | Register write data |
| regRdData | output | 16 | Combinational read data of the selected register |

## Verification
The one pair of functions that can land on the same clock is the commit triggered by a STOP and a software write-1 clear of the status flag that this commit sets. The bench raises SDA while SCL is high and then counts the two synchronizer stages and the edge register, so that its status write is sampled on exactly the clock edge at which the commit updates status. The flag must read 1 afterwards, and the capture must hold the new value. A second clear one clock later must then bring the flag to 0.

// File: rtl/smbNotifyPkg.sv
package smbNotifyPkg;
  localparam int ADDR_W       = 7;
  localparam int BYTE_W       = 8;
  localparam int WORD_W       = 2 * BYTE_W;
  localparam int REG_SEL_W    = 3;
  localparam int BIT_CNT_W    = 4;
  localparam int BYTE_CNT_W   = 3;
  localparam int LAST_BIT     = BYTE_W - 1;
  localparam int ACK_BIT      = BYTE_W;
  localparam int HOST_BYTES   = 4;
  localparam int HOST_BYTES10 = 5;
  localparam int SNOOP_BYTES  = 2;
  localparam logic [ADDR_W-1:0] ADDR_RESET = 7'h08;
  localparam logic [4:0] TEN_BIT_PREFIX = 5'b11110;

  localparam logic [REG_SEL_W-1:0] SEL_HOST = 3'd0;
  localparam logic [REG_SEL_W-1:0] SEL_SNP  = 3'd1;
  localparam logic [REG_SEL_W-1:0] SEL_CAP  = 3'd2;
  localparam logic [REG_SEL_W-1:0] SEL_DATA = 3'd3;
  localparam logic [REG_SEL_W-1:0] SEL_STS  = 3'd4;

  typedef enum logic [1:0] {MODE_NONE, MODE_HOST, MODE_SNOOP} busMode_t;

  typedef struct packed {
    logic              ldCmd;
    logic              ldExt;
    logic              ldLo;
    logic              ldHi;
    logic              commitHost;
    logic              commitSnoop;
    logic [BYTE_W-1:0] byteVal;
  } ctrlStrobe_t;
endpackage

// File: rtl/smbNotifySync.sv
module smbNotifySync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : gStage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[g] <= RST_VAL;
        else if (g == 0) chain[g] <= asyncIn;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/smbNotifyCtrl.sv
module smbNotifyCtrl
  import smbNotifyPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclS,
  input  logic              sdaS,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              pullLow,
  output ctrlStrobe_t       st
);
  logic sclPrev, sdaPrev;
  logic startDet, stopDet, sclRise, sclFall;
  logic active, tenBit, ackPending;
  logic [BIT_CNT_W-1:0]  bitCnt;
  logic [BYTE_CNT_W-1:0] byteCnt, loIdx, hiIdx, needCnt, lastNow;
  logic [BYTE_W-1:0]     shiftReg, newByte;
  busMode_t mode, modeNext;
  logic byteEnd, hostHit, snoopHit, tenNow, ackNext;

  assign startDet = sclS && sclPrev && sdaPrev && !sdaS;
  assign stopDet  = sclS && sclPrev && !sdaPrev && sdaS;
  assign sclRise  = sclS && !sclPrev;
  assign sclFall  = !sclS && sclPrev;
  assign newByte  = {shiftReg[BYTE_W-2:0], sdaS};
  assign byteEnd  = active && sclRise && (bitCnt == BIT_CNT_W'(LAST_BIT));

  assign hostHit  = (newByte[BYTE_W-1:1] == hostAddr) && !newByte[0];
  assign snoopHit = (newByte[BYTE_W-1:1] == snpAddr) && (snpAddr != hostAddr);
  assign modeNext = hostHit ? MODE_HOST : (snoopHit ? MODE_SNOOP : MODE_NONE);

  assign tenNow  = (byteCnt == 3'd1) ? (newByte[BYTE_W-1:3] == TEN_BIT_PREFIX) : tenBit;
  assign lastNow = tenNow ? BYTE_CNT_W'(HOST_BYTES10 - 1) : BYTE_CNT_W'(HOST_BYTES - 1);
  assign ackNext = (byteCnt == 3'd0) ? hostHit : ((mode == MODE_HOST) && (byteCnt <= lastNow));

  assign loIdx   = tenBit ? 3'd3 : 3'd2;
  assign hiIdx   = tenBit ? 3'd4 : 3'd3;
  assign needCnt = tenBit ? BYTE_CNT_W'(HOST_BYTES10) : BYTE_CNT_W'(HOST_BYTES);

  always_comb begin
    st             = '0;
    st.byteVal     = newByte;
    st.ldCmd       = byteEnd && (mode != MODE_NONE) && (byteCnt == 3'd1);
    st.ldExt       = byteEnd && (mode == MODE_HOST) && tenBit && (byteCnt == 3'd2);
    st.ldLo        = byteEnd && (mode == MODE_HOST) && (byteCnt == loIdx);
    st.ldHi        = byteEnd && (mode == MODE_HOST) && (byteCnt == hiIdx);
    st.commitHost  = stopDet && active && (mode == MODE_HOST) && (byteCnt >= needCnt);
    st.commitSnoop = stopDet && active && (mode == MODE_SNOOP) &&
                     (byteCnt >= BYTE_CNT_W'(SNOOP_BYTES));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev    <= 1'b1;
      sdaPrev    <= 1'b1;
      active     <= 1'b0;
      bitCnt     <= '0;
      byteCnt    <= '0;
      shiftReg   <= '0;
      mode       <= MODE_NONE;
      tenBit     <= 1'b0;
      ackPending <= 1'b0;
      pullLow    <= 1'b0;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
      if (startDet) begin
        active     <= 1'b1;
        bitCnt     <= '0;
        byteCnt    <= '0;
        mode       <= MODE_NONE;
        tenBit     <= 1'b0;
        ackPending <= 1'b0;
        pullLow    <= 1'b0;
      end else if (stopDet) begin
        active     <= 1'b0;
        mode       <= MODE_NONE;
        ackPending <= 1'b0;
        pullLow    <= 1'b0;
      end else if (active) begin
        if (sclRise) begin
          if (bitCnt == BIT_CNT_W'(ACK_BIT)) begin
            bitCnt <= '0;
          end else begin
            shiftReg <= newByte;
            bitCnt   <= bitCnt + 1'b1;
          end
          if (byteEnd) begin
            if (byteCnt != '1) byteCnt <= byteCnt + 1'b1;
            ackPending <= ackNext;
            if (byteCnt == 3'd0) mode <= modeNext;
            if (byteCnt == 3'd1) tenBit <= tenNow;
          end
        end
        if (sclFall) pullLow <= (bitCnt == BIT_CNT_W'(ACK_BIT)) && ackPending;
      end
    end
  end

  AST_COMMIT_AT_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (st.commitHost || st.commitSnoop) |-> stopDet) else $error("commit without STOP"); // R5
  AST_ACK_WHILE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pullLow) |-> !sclS) else $error("ack started with SCL high"); // R8
  AST_NO_SNOOP_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_SNOOP) |-> !pullLow) else $error("snooped byte acknowledged"); // R8
  AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.commitHost, st.commitSnoop})) else $error("two commits at once"); // R6
endmodule

// File: rtl/smbNotifyData.sv
module smbNotifyData
  import smbNotifyPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          st,
  input  logic                 regWrEn,
  input  logic [REG_SEL_W-1:0] regAddr,
  input  logic [BYTE_W-1:0]    regWrData,
  output logic [WORD_W-1:0]    regRdData,
  output logic [ADDR_W-1:0]    hostAddr,
  output logic [ADDR_W-1:0]    snpAddr
);
  logic [BYTE_W-1:0] stgCmd, stgExt, stgLo, stgHi;
  logic [WORD_W-1:0] capReg, dataReg;
  logic hostSts, snpSts, wrSts, tenCap;

  assign wrSts  = regWrEn && (regAddr == SEL_STS);
  assign tenCap = (stgCmd[BYTE_W-1:3] == TEN_BIT_PREFIX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stgCmd <= '0;
      stgExt <= '0;
      stgLo  <= '0;
      stgHi  <= '0;
    end else begin
      if (st.ldCmd) stgCmd <= st.byteVal;
      if (st.ldExt) stgExt <= st.byteVal;
      if (st.ldLo)  stgLo  <= st.byteVal;
      if (st.ldHi)  stgHi  <= st.byteVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capReg  <= '0;
      dataReg <= '0;
    end else if (st.commitHost) begin
      capReg  <= {(tenCap ? stgExt : {BYTE_W{1'b0}}), stgCmd[BYTE_W-1:1], 1'b0};
      dataReg <= {stgHi, stgLo};
    end else if (st.commitSnoop) begin
      capReg  <= {{BYTE_W{1'b0}}, stgCmd};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostAddr <= ADDR_RESET;
      snpAddr  <= ADDR_RESET;
      hostSts  <= 1'b0;
      snpSts   <= 1'b0;
    end else begin
      if (regWrEn && regAddr == SEL_HOST) hostAddr <= regWrData[BYTE_W-1:1];
      if (regWrEn && regAddr == SEL_SNP)  snpAddr  <= regWrData[BYTE_W-1:1];
      hostSts <= st.commitHost  | (hostSts & ~(wrSts & regWrData[0]));
      snpSts  <= st.commitSnoop | (snpSts  & ~(wrSts & regWrData[1]));
    end
  end

  always_comb begin
    case (regAddr)
      SEL_HOST: regRdData = {{BYTE_W{1'b0}}, hostAddr, 1'b0};
      SEL_SNP:  regRdData = {{BYTE_W{1'b0}}, snpAddr, 1'b0};
      SEL_CAP:  regRdData = capReg;
      SEL_DATA: regRdData = dataReg;
      SEL_STS:  regRdData = {{(WORD_W-2){1'b0}}, snpSts, hostSts};
      default:  regRdData = '0;
    endcase
  end

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    st.commitHost |=> hostSts) else $error("host flag lost on commit"); // R10
  AST_SNP_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    st.commitSnoop |=> snpSts) else $error("snoop flag lost on commit"); // R10
  AST_CAP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !(st.commitHost || st.commitSnoop) |=> $stable(capReg)) else $error("capture moved"); // R9
  AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !st.commitHost |=> $stable(dataReg)) else $error("data word moved"); // R6
endmodule

// File: rtl/smbNotifySnoop.sv
module smbNotifySnoop
  import smbNotifyPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  output logic                 sdaPullLow,
  input  logic                 regWrEn,
  input  logic [REG_SEL_W-1:0] regAddr,
  input  logic [BYTE_W-1:0]    regWrData,
  output logic [WORD_W-1:0]    regRdData
);
  logic sclS, sdaS;
  logic [ADDR_W-1:0] hostAddr, snpAddr;
  ctrlStrobe_t st;

  smbNotifySync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sclSync (
    .clk(clk), .rstN(rstN), .asyncIn(sclIn), .syncOut(sclS));
  smbNotifySync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sdaSync (
    .clk(clk), .rstN(rstN), .asyncIn(sdaIn), .syncOut(sdaS));

  smbNotifyCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .sclS(sclS), .sdaS(sdaS),
    .hostAddr(hostAddr), .snpAddr(snpAddr), .pullLow(sdaPullLow), .st(st));

  smbNotifyData i_data (
    .clk(clk), .rstN(rstN), .st(st), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .hostAddr(hostAddr), .snpAddr(snpAddr));
endmodule

// File: tb/test_smbNotifySnoop.sv
`timescale 1ns/1ps
module test_smbNotifySnoop;
  localparam int H = 6;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1, sdaDrv = 1'b1;
  logic sdaPullLow, sdaLine;
  logic regWrEn = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [7:0] regWrData = 8'd0;
  logic [15:0] regRdData;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  assign sdaLine = sdaDrv & ~sdaPullLow;

  smbNotifySnoop i_smbNotifySnoop (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine), .sdaPullLow(sdaPullLow),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk); regAddr = a; #1 v = regRdData;
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic expReg(input string req, input logic [2:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rdReg(a, v); check(req, v, exp);
  endtask

  task automatic busStart;
    sdaDrv = 1'b1; waitClk(H); sclDrv = 1'b1; waitClk(H);
    sdaDrv = 1'b0; waitClk(H); sclDrv = 1'b0; waitClk(H);
  endtask

  task automatic busStop;
    sdaDrv = 1'b0; waitClk(H); sclDrv = 1'b1; waitClk(H); sdaDrv = 1'b1; waitClk(H);
  endtask

  task automatic busByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaDrv = b[i]; waitClk(H); sclDrv = 1'b1; waitClk(H); sclDrv = 1'b0;
    end
    sdaDrv = 1'b1; waitClk(H); sclDrv = 1'b1; waitClk(H/2);
    ack = ~sdaLine; waitClk(H - H/2); sclDrv = 1'b0; waitClk(H);
  endtask

  task automatic sendBytes(input logic [7:0] b[], input string req, input logic expAck[]);
    logic a;
    foreach (b[i]) begin
      busByte(b[i], a);
      check(req, {15'd0, a}, {15'd0, expAck[i]});
    end
  endtask

  task automatic testReset;
    expReg("R1 host addr", 3'd0, 16'h0010);
    expReg("R1 snoop addr", 3'd1, 16'h0010);
    expReg("R1 capture", 3'd2, 16'h0000);
    expReg("R1 data", 3'd3, 16'h0000);
    expReg("R1 status", 3'd4, 16'h0000);
    check("R1 pull", {15'd0, sdaPullLow}, 16'd0);
  endtask

  task automatic testRegs;
    wrReg(3'd0, 8'h15); expReg("R2 host bit0 zero", 3'd0, 16'h0014);
    wrReg(3'd0, 8'h10); expReg("R2 host restore", 3'd0, 16'h0010);
    wrReg(3'd1, 8'h58); expReg("R2 snoop addr", 3'd1, 16'h0058);
    wrReg(3'd2, 8'hFF); expReg("R2 capture ro", 3'd2, 16'h0000);
    wrReg(3'd3, 8'hFF); expReg("R2 data ro", 3'd3, 16'h0000);
  endtask

  task automatic testHostWord;
    busStart();
    sendBytes('{8'h10, 8'hA7, 8'h34, 8'h12}, "R8 host ack", '{1, 1, 1, 1});
    expReg("R5 no status before stop", 3'd4, 16'h0000);
    busStop();
    expReg("R3 capture", 3'd2, 16'h00A6);
    expReg("R3 data", 3'd3, 16'h1234);
    expReg("R3 status", 3'd4, 16'h0001);
    wrReg(3'd4, 8'h02); expReg("R10 write 0 keeps", 3'd4, 16'h0001);
    wrReg(3'd4, 8'h01); expReg("R10 write 1 clears", 3'd4, 16'h0000);
  endtask

  task automatic testTenBit;
    busStart();
    sendBytes('{8'h10, 8'hF3, 8'h5A, 8'hCD, 8'hAB, 8'h77}, "R8 ten-bit ack", '{1, 1, 1, 1, 1, 0});
    busStop();
    expReg("R4 capture", 3'd2, 16'h5AF2);
    expReg("R4 data", 3'd3, 16'hABCD);
    expReg("R4 status", 3'd4, 16'h0001);
    wrReg(3'd4, 8'h01);
  endtask

  task automatic testHostRead;
    busStart();
    sendBytes('{8'h11, 8'h22, 8'h33, 8'h44}, "R3 read not acked", '{0, 0, 0, 0});
    busStop();
    expReg("R3 read no status", 3'd4, 16'h0000);
    expReg("R3 read no capture", 3'd2, 16'h5AF2);
  endtask

  task automatic testSnoop;
    busStart();
    sendBytes('{8'h58, 8'h3C, 8'h01, 8'h02}, "R8 snoop no ack", '{0, 0, 0, 0});
    busStop();
    expReg("R6 write capture", 3'd2, 16'h003C);
    expReg("R6 data kept", 3'd3, 16'hABCD);
    expReg("R6 write status", 3'd4, 16'h0002);
    wrReg(3'd4, 8'h02);
    busStart();
    sendBytes('{8'h59, 8'h81}, "R8 snoop read no ack", '{0, 0});
    busStop();
    expReg("R6 read capture", 3'd2, 16'h0081);
    expReg("R6 read status", 3'd4, 16'h0002);
    wrReg(3'd4, 8'h02);
    busStart();
    sendBytes('{8'h40, 8'h55}, "R8 unmatched no ack", '{0, 0});
    busStop();
    expReg("R8 unmatched no status", 3'd4, 16'h0000);
  endtask

  task automatic testIncomplete;
    busStart();
    sendBytes('{8'h10, 8'h44, 8'h66}, "R9 partial ack", '{1, 1, 1});
    busStop();
    expReg("R9 stop early capture", 3'd2, 16'h0081);
    expReg("R9 stop early status", 3'd4, 16'h0000);
    busStart();
    sendBytes('{8'h10, 8'h48}, "R9 before restart", '{1, 1});
    busStart();
    sendBytes('{8'h10, 8'h62, 8'h11, 8'h22}, "R9 after restart", '{1, 1, 1, 1});
    busStop();
    expReg("R9 restart capture", 3'd2, 16'h0062);
    expReg("R9 restart data", 3'd3, 16'h2211);
    expReg("R9 restart status", 3'd4, 16'h0001);
    wrReg(3'd4, 8'h01);
  endtask

  task automatic testEqual;
    wrReg(3'd1, 8'h10);
    busStart();
    sendBytes('{8'h11, 8'h99}, "R7 equal read no ack", '{0, 0});
    busStop();
    expReg("R7 equal read status", 3'd4, 16'h0000);
    expReg("R7 equal read capture", 3'd2, 16'h0062);
    busStart();
    sendBytes('{8'h10, 8'h30, 8'h01, 8'h02}, "R7 equal write ack", '{1, 1, 1, 1});
    busStop();
    expReg("R7 equal write status", 3'd4, 16'h0001);
    expReg("R7 equal write capture", 3'd2, 16'h0030);
    wrReg(3'd4, 8'h03);
    wrReg(3'd1, 8'h58);
  endtask

  task automatic testSetVsClear;
    busStart();
    sendBytes('{8'h10, 8'h2A, 8'h0F, 8'hF0}, "R10 same-cycle ack", '{1, 1, 1, 1});
    sdaDrv = 1'b0; waitClk(H); sclDrv = 1'b1; waitClk(H);
    sdaDrv = 1'b1;
    waitClk(2);
    regWrEn = 1'b1; regAddr = 3'd4; regWrData = 8'h01;
    @(negedge clk); regWrEn = 1'b0;
    expReg("R10 set wins", 3'd4, 16'h0001);
    expReg("R10 capture at tie", 3'd2, 16'h002A);
    wrReg(3'd4, 8'h01);
    expReg("R10 later clear", 3'd4, 16'h0000);
  endtask

  initial begin
    waitClk(4);
    rstN = 1'b1;
    waitClk(4);
    testReset();
    testRegs();
    testHostWord();
    testTenBit();
    testHostRead();
    testSnoop();
    testIncomplete();
    testEqual();
    testSetVsClear();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule